// File: doc/BRIEF.md
# Single-Cycle 16-bit Load/Store Processor Core

This block is a small processor core that completes one instruction per clock. Each instruction is a 16-bit word. A program counter holds a byte address that selects the word to fetch from an internal instruction store. The top four bits of the word are an opcode, and the core decodes them into the controls for the register file, the ALU, the data memory and the next-PC selector. In the same cycle it executes register and immediate arithmetic and logic, a signed set-less-than, word loads and stores, a not-equal branch and an absolute jump.

The instruction store is loaded through a plain write port. The port is normally driven while reset is held, and the core then runs from address 0 once reset is released. The register write-back, the data-memory write and the fetched word with its address are all visible at the ports. These outputs are how the surrounding logic, or a bench, follows execution.

Instruction fields are laid out as follows:

- [15:12]: opcode.
- [11:8]: destination register. This field names the stored register for a store and the first compared register for a branch.
- [7:4]: first source or base register.
- [3:0]: second source register, or a 4-bit immediate.
- [11:0]: jump field, used by the jump instruction.

Top module: `cpu16_core`

## Requirements
- R1: While `rst_n` is low, and for the two clocks after it rises, the PC stays at 0. Every register also reads 0 after reset.
- R2: Any opcode other than 1001 and 1010 moves the PC to PC+2. The PC is always even.
- R3: Opcodes 0000, 0001, 0010 and 0011 write rd = rs+rt, rs-rt, rs AND rt and rs OR rt, respectively.
- R4: Opcode 0100 writes rd = rs + imm and opcode 0101 writes rd = rs - imm. In both cases imm is bits [3:0] sign-extended to 16 bits.
- R5: Opcode 0111 writes 1 to rd when rs < rt as signed 16-bit values, and writes 0 otherwise.
- R6: Register 0 always reads 0. A write aimed at it is still shown on the write-back port but has no effect.
- R7: Opcode 1000 loads rd from data word (rs + imm). Opcode 1100 stores register rd to data word (rs + imm) and writes no register. The word index is the low 6 bits of the sum.
- R8: Opcode 1001 compares register rd with register rs. When they differ, the PC becomes PC+2+(imm<<1). When they are equal, the PC becomes PC+2.
- R9: Opcode 1010 sets the PC to {PC[15:13], instr[11:0], 0}.
- R10: Opcodes 0110, 1011, 1101, 1110 and 1111 write neither a register nor data memory.
- R11: A word written through the instruction write port at word index i is executed when the PC equals 2*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a 2-stage synchronizer |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IAW (6) | Instruction word index to write |
| imem_wdata | input | 16 | Instruction word to write |
| pc_o | output | 16 | Current program counter (byte address) |
| instr_o | output | 16 | Instruction being executed |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 4 | Register written |
| rf_wdata_o | output | 16 | Value written |
| dm_we_o | output | 1 | Data memory write this cycle |
| dm_addr_o | output | DAW (6) | Data word index accessed |
| dm_wdata_o | output | 16 | Data written to memory |

## Verification
The bench builds the core with its defaults: 64 instruction words and 64 data words. At this size, a 12-bit jump field can reach any program slot. Backward and forward branch offsets, and negative load/store displacements, also land inside the program, so every next-PC path and the sign extension of the immediate can be seen at the ports. Negative operands are placed on purpose so that a signed set-less-than and an unsigned one would give different results.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
  localparam int XLEN = 16;
  localparam int RSEL = 4;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h3;
  localparam logic [3:0] OP_ADDI = 4'h4;
  localparam logic [3:0] OP_SUBI = 4'h5;
  localparam logic [3:0] OP_SLT  = 4'h7;
  localparam logic [3:0] OP_LW   = 4'h8;
  localparam logic [3:0] OP_BNE  = 4'h9;
  localparam logic [3:0] OP_JMP  = 4'hA;
  localparam logic [3:0] OP_SW   = 4'hC;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    use_imm;
    logic    mem_we;
    logic    mem_rd;
    logic    br_ne;
    logic    jmp;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/cpu16_decode.sv
`timescale 1ns/1ps
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{rf_we: 1'b0, use_imm: 1'b0, mem_we: 1'b0, mem_rd: 1'b0,
             br_ne: 1'b0, jmp: 1'b0, alu_op: ALU_ADD};
    case (opcode)
      OP_ADD:  ctrl.rf_we = 1'b1;
      OP_SUB:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SUB; end
      OP_AND:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_AND; end
      OP_OR:   begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_OR;  end
      OP_ADDI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_SUBI: begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SUB; end
      OP_SLT:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SLT; end
      OP_LW:   begin ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; end
      OP_SW:   begin ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_BNE:  ctrl.br_ne = 1'b1;
      OP_JMP:  ctrl.jmp = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs_q [NREG];
  logic [NREG-1:0] wen;

  always_comb begin
    for (int i = 0; i < NREG; i++) wen[i] = we && (waddr == AW'(i));
  end

  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[g] <= '0;
      else if (wen[g]) regs_q[g] <= wdata;
    end
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];
  assign rd3 = regs_q[ra3];
endmodule

// File: rtl/cpu16_dmem.sv
`timescale 1ns/1ps
module cpu16_dmem #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [XLEN-1:0] imem_wdata,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o,
  output logic            rf_we_o,
  output logic [RSEL-1:0] rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [DAW-1:0]  dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  // reset: asserted at once, released after two clocks
  logic [1:0] sync_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  // instruction store
  logic [XLEN-1:0] imem [IMEM_WORDS];
  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  logic [XLEN-1:0] pc_q, pc_d, instr;
  assign instr = imem[pc_q[IAW:1]];

  logic [3:0]      opcode;
  logic [RSEL-1:0] f_rd, f_rs, f_rt;
  logic [XLEN-1:0] imm;
  assign opcode = instr[15:12];
  assign f_rd   = instr[11:8];
  assign f_rs   = instr[7:4];
  assign f_rt   = instr[3:0];
  assign imm    = {{(XLEN-4){instr[3]}}, instr[3:0]};

  ctrl_t ctrl;
  cpu16_decode u_dec (.opcode(opcode), .ctrl(ctrl));

  logic [XLEN-1:0] v_rs, v_rt, v_rd, alu_b, alu_y, dm_rdata, wb_data;
  logic rf_we, dm_we;
  assign rf_we = ctrl.rf_we & run;
  assign dm_we = ctrl.mem_we & run;

  cpu16_regfile #(.W(XLEN), .NREG(1 << RSEL)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(f_rd), .wdata(wb_data),
    .ra1(f_rs), .ra2(f_rt), .ra3(f_rd), .rd1(v_rs), .rd2(v_rt), .rd3(v_rd)
  );

  assign alu_b = ctrl.use_imm ? imm : v_rt;
  cpu16_alu #(.W(XLEN)) u_alu (.a(v_rs), .b(alu_b), .op(ctrl.alu_op), .y(alu_y));

  cpu16_dmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dm (
    .clk(clk), .we(dm_we), .addr(alu_y[DAW-1:0]), .wdata(v_rd), .rdata(dm_rdata)
  );

  assign wb_data = ctrl.mem_rd ? dm_rdata : alu_y;

  // next-PC selection
  logic [XLEN-1:0] pc_seq, pc_br, pc_jmp;
  assign pc_seq = pc_q + XLEN'(2);
  assign pc_br  = pc_seq + {imm[XLEN-2:0], 1'b0};
  assign pc_jmp = {pc_q[XLEN-1:13], instr[11:0], 1'b0};

  always_comb begin
    if (ctrl.jmp)                       pc_d = pc_jmp;
    else if (ctrl.br_ne && v_rd != v_rs) pc_d = pc_br;
    else                                pc_d = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = f_rd;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y[DAW-1:0];
  assign dm_wdata_o = v_rd;
endmodule

// File: rtl/cpu16_core_chk.sv
`timescale 1ns/1ps
module cpu16_core_chk (
  input logic        clk,
  input logic        run,
  input logic [15:0] pc,
  input logic [15:0] instr,
  input logic        rf_we,
  input logic        dm_we,
  input logic [15:0] wdata
);
  logic [3:0] op;
  assign op = instr[15:12];

  assert_pc_even_R2: assert property (@(posedge clk) disable iff (!run)
    pc[0] == 1'b0);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!run)
    (op != 4'h9 && op != 4'hA) |=> pc == $past(pc) + 16'd2);

  assert_jmp_target_R9: assert property (@(posedge clk) disable iff (!run)
    (op == 4'hA) |=> pc == {$past(pc[15:13]), $past(instr[11:0]), 1'b0});

  assert_bne_target_R8: assert property (@(posedge clk) disable iff (!run)
    (op == 4'h9) |=> (pc == $past(pc) + 16'd2) ||
      (pc == $past(pc) + 16'd2 + {{11{$past(instr[3])}}, $past(instr[3:0]), 1'b0}));

  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!run)
    (op == 4'h6 || op == 4'hB || op == 4'hD || op == 4'hE || op == 4'hF)
      |-> (!rf_we && !dm_we));

  assert_slt_bool_R5: assert property (@(posedge clk) disable iff (!run)
    (op == 4'h7) |-> (rf_we && wdata[15:1] == 15'd0));

  assert_store_nowb_R7: assert property (@(posedge clk) disable iff (!run)
    (op == 4'hC) |-> (dm_we && !rf_we));
endmodule

bind cpu16_core cpu16_core_chk u_chk (
  .clk(clk), .run(run), .pc(pc_o), .instr(instr_o),
  .rf_we(rf_we_o), .dm_we(dm_we_o), .wdata(rf_wdata_o)
);

// File: tb/cpu16_core_bench.sv
`timescale 1ns/1ps
module cpu16_core_bench;
  localparam int IW = 64;
  localparam logic [15:0] NOP = 16'h6000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [15:0] imem_wdata = '0;
  logic [15:0] pc_o, instr_o, rf_wdata_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [3:0]  rf_waddr_o;
  logic [5:0]  dm_addr_o;

  cpu16_core u_cpu16_core (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] prog [IW];

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] a,
                                      input logic [3:0] b, input logic [3:0] c);
    return {op, a, b, c};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IW; i++) prog[i] = NOP;
  endtask

  // R11: program is written through the port while reset is held
  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) begin
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wb(input string tag, input logic [15:0] epc,
                    input logic [3:0] ea, input logic [15:0] ed);
    check({tag, " pc"}, pc_o, epc);
    check({tag, " we"}, 16'(rf_we_o), 16'd1);
    check({tag, " addr"}, 16'(rf_waddr_o), 16'(ea));
    check({tag, " data"}, rf_wdata_o, ed);
    @(negedge clk);
  endtask

  task automatic quiet(input string tag, input logic [15:0] epc);
    check({tag, " pc"}, pc_o, epc);
    check({tag, " rf_we"}, 16'(rf_we_o), 16'd0);
    check({tag, " dm_we"}, 16'(dm_we_o), 16'd0);
    @(negedge clk);
  endtask

  task automatic t_alu();
    clear_prog();
    prog[0] = enc(4'h4, 4'd1, 4'd0, 4'd5);
    prog[1] = enc(4'h4, 4'd2, 4'd0, 4'hD);
    prog[2] = enc(4'h0, 4'd3, 4'd1, 4'd2);
    prog[3] = enc(4'h1, 4'd4, 4'd1, 4'd2);
    prog[4] = enc(4'h2, 4'd5, 4'd1, 4'd2);
    prog[5] = enc(4'h3, 4'd6, 4'd1, 4'd2);
    prog[6] = enc(4'h5, 4'd7, 4'd1, 4'd7);
    prog[7] = enc(4'h7, 4'd8, 4'd2, 4'd1);
    prog[8] = enc(4'h7, 4'd9, 4'd1, 4'd2);
    boot();
    wb("R4 addi", 16'd0, 4'd1, 16'd5);
    wb("R4 addi neg", 16'd2, 4'd2, 16'hFFFD);
    wb("R3 add", 16'd4, 4'd3, 16'd2);
    wb("R3 sub", 16'd6, 4'd4, 16'd8);
    wb("R3 and", 16'd8, 4'd5, 16'h0005);
    wb("R3 or", 16'd10, 4'd6, 16'hFFFD);
    wb("R4 subi", 16'd12, 4'd7, 16'hFFFE);
    wb("R5 slt true", 16'd14, 4'd8, 16'd1);
    wb("R5 slt false", 16'd16, 4'd9, 16'd0);
    check("R2 seq pc", pc_o, 16'd18);
  endtask

  task automatic t_reset_r0();
    clear_prog();
    prog[0] = enc(4'h0, 4'd1, 4'd2, 4'd3);
    prog[1] = enc(4'h4, 4'd0, 4'd0, 4'd7);
    prog[2] = enc(4'h0, 4'd1, 4'd0, 4'd0);
    boot();
    wb("R1 regs cleared", 16'd0, 4'd1, 16'd0);
    wb("R6 write r0", 16'd2, 4'd0, 16'd7);
    wb("R6 r0 reads zero", 16'd4, 4'd1, 16'd0);
  endtask

  task automatic t_mem();
    clear_prog();
    prog[0] = enc(4'h4, 4'd1, 4'd0, 4'd3);
    prog[1] = enc(4'h4, 4'd2, 4'd0, 4'hA);
    prog[2] = enc(4'hC, 4'd2, 4'd1, 4'd2);
    prog[3] = enc(4'h8, 4'd3, 4'd1, 4'd2);
    prog[4] = enc(4'h4, 4'd4, 4'd0, 4'd7);
    prog[5] = enc(4'hC, 4'd1, 4'd4, 4'hF);
    prog[6] = enc(4'h8, 4'd5, 4'd0, 4'd6);
    boot();
    wb("R7 setup", 16'd0, 4'd1, 16'd3);
    wb("R7 setup", 16'd2, 4'd2, 16'hFFFA);
    check("R7 sw we", 16'(dm_we_o), 16'd1);
    check("R7 sw addr", 16'(dm_addr_o), 16'd5);
    check("R7 sw data", dm_wdata_o, 16'hFFFA);
    check("R7 sw no rf", 16'(rf_we_o), 16'd0);
    @(negedge clk);
    wb("R7 lw", 16'd6, 4'd3, 16'hFFFA);
    wb("R7 setup", 16'd8, 4'd4, 16'd7);
    check("R7 sw neg addr", 16'(dm_addr_o), 16'd6);
    check("R7 sw neg data", dm_wdata_o, 16'd3);
    @(negedge clk);
    wb("R7 lw neg", 16'd12, 4'd5, 16'd3);
  endtask

  task automatic t_branch();
    clear_prog();
    prog[0] = enc(4'h4, 4'd1, 4'd0, 4'd1);
    prog[1] = enc(4'h9, 4'd1, 4'd0, 4'd2);
    prog[4] = enc(4'h9, 4'd0, 4'd0, 4'hE);
    prog[5] = enc(4'h4, 4'd2, 4'd0, 4'd1);
    prog[6] = enc(4'h9, 4'd2, 4'd1, 4'd3);
    prog[7] = enc(4'h9, 4'd1, 4'd0, 4'h8);
    boot();
    wb("R8 setup", 16'd0, 4'd1, 16'd1);
    quiet("R8 bne", 16'd2);
    quiet("R8 taken fwd", 16'd8);
    check("R8 eq not taken", pc_o, 16'd10);
    @(negedge clk);
    quiet("R8 bne eq", 16'd12);
    quiet("R8 eq not taken2", 16'd14);
    wb("R8 taken back", 16'd0, 4'd1, 16'd1);
  endtask

  task automatic t_jump();
    clear_prog();
    prog[0]  = enc(4'hA, 4'h0, 4'h1, 4'h0);
    prog[16] = 16'h6123;
    prog[17] = 16'hF456;
    prog[18] = 16'hB000;
    prog[19] = 16'hD111;
    prog[20] = 16'hE222;
    prog[21] = enc(4'hA, 4'h0, 4'h0, 4'h2);
    prog[2]  = enc(4'h4, 4'd3, 4'd0, 4'd4);
    boot();
    quiet("R9 jmp", 16'd0);
    quiet("R10 op6", 16'h20);
    quiet("R10 opF", 16'h22);
    quiet("R10 opB", 16'h24);
    quiet("R10 opD", 16'h26);
    quiet("R10 opE", 16'h28);
    quiet("R9 jmp back", 16'h2A);
    wb("R9 R11 landed", 16'd4, 4'd3, 16'd4);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_o, 16'd0);
    t_alu();
    t_reset_r0();
    t_mem();
    t_branch();
    t_jump();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule